// File: doc/BRIEF.md
# Block transfer address sequencer

This unit walks through a multi-register memory transfer, one word per cycle. A single start pulse hands it a base address, a register mask, a two-bit walk mode and three flags: write back the base, load or store, and the status-restore/user-bank flag. The unit then offers one word address per cycle on a valid/ready request port. Each request carries the index of the register that the word belongs to. Registers go out in rising index order and the address steps up by one word after each accepted request.

After the last request is accepted, the unit raises a one-cycle completion pulse. With the pulse come the new base value and its enable, plus three side-effect flags. The first tells the core that the program counter was loaded, so it must not advance it sequentially. The second asks the core to copy the saved status word into the current one. The third tells the core to use the user register bank for the transfer. The memory and the register file live outside the block. An empty mask finishes at once and issues no request.

Top module: `blk_xfer_seq`

## Requirements
- R1: An accepted start issues exactly as many requests as there are set bits in the 16-bit mask. `req_valid_o` is high only while requests are outstanding.
- R2: Requests carry register indices in ascending order. The address of each request is 4 above the address of the previous one.
- R3: The first address depends on `mode_i`, where n is the mask's bit count. Mode 0 gives base. Mode 1 gives base + 4. Mode 2 gives base − 4n + 4. Mode 3 gives base − 4n. All arithmetic wraps modulo 2^32.
- R4: During the completion pulse, `wb_en_o` equals the write-back flag. `wb_value_o` is base + 4n for modes 0 and 1 (bit 1 of the mode clear) and base − 4n for modes 2 and 3. Outside the pulse, both outputs read 0.
- R5: While `req_valid_o` is high and `req_ready_i` is low, the address and index are held.
- R6: `pc_load_o` is high during the completion pulse exactly when the transfer is a load and mask bit 15 is set. `req_load_o` follows the load flag while a request is valid.
- R7: During the completion pulse, `psr_restore_o` is high exactly for a load with S set and bit 15 set. `user_bank_o` is high exactly when S is set and that case does not hold.
- R8: An empty mask raises `done_o` in the cycle after the start edge and issues no request.
- R9: `done_o` lasts one cycle and follows the edge of the last handshake. A start while `busy_o` is high is ignored.
- R10: After reset, `busy_o`, `req_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| base_i | input | 32 | Base address |
| list_i | input | 16 | Register mask |
| mode_i | input | 2 | Walk mode 0..3 |
| wback_i | input | 1 | Write the base back |
| load_i | input | 1 | 1 = load, 0 = store |
| sbit_i | input | 1 | Status-restore / user-bank flag |
| busy_o | output | 1 | Operation in progress (including the done cycle) |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_addr_o | output | 32 | Word address |
| req_idx_o | output | 4 | Register index |
| req_load_o | output | 1 | Direction of the request |
| done_o | output | 1 | Completion pulse |
| wb_en_o | output | 1 | Base write-back enable |
| wb_value_o | output | 32 | New base value |
| pc_load_o | output | 1 | Program counter loaded |
| psr_restore_o | output | 1 | Copy saved status word to current |
| user_bank_o | output | 1 | Use the user register bank |

## Verification
The assertions assume that `req_ready_i` may change in any cycle, with no dependence on `req_valid_o`. They also assume that start and its operands are sampled only on an idle cycle, so operands that change while busy must leave the sequence untouched. The stimulus drives all inputs on the falling edge and holds start for one cycle. It randomises the ready duty cycle per operation. It also pulses start with different operands in the middle of a transfer, so the ignore rule is exercised without breaking the assumption of a clean request stream.

// File: rtl/blk_xfer_pkg.sv
// Shared types for the block transfer sequencer.
// Assumes: mode encoding bit 1 selects the decrementing walks.
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        WALK_INC_AFTER  = 2'd0,
        WALK_INC_BEFORE = 2'd1,
        WALK_DEC_AFTER  = 2'd2,
        WALK_DEC_BEFORE = 2'd3
    } walk_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_FINISH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/xfer_popcount.sv
// Counts the set bits of a mask through a chain of partial sums.
// Assumes: CNT_W is wide enough for N.
module xfer_popcount #(
    parameter int N     = 16,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     bits_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] partial [N+1];

    assign partial[0] = '0;

    // One adder stage per mask bit
    for (genvar g = 0; g < N; g++) begin : g_sum
        assign partial[g+1] = partial[g] + CNT_W'(bits_i[g]);
    end

    assign count_o = partial[N];
endmodule

// File: rtl/xfer_addr_plan.sv
// Computes the first word address and the written-back base from
// base, bit count and walk mode.
// Assumes: WORD_BYTES is a power of two.
module xfer_addr_plan
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  walk_mode_e        mode_i,
    output logic [ADDR_W-1:0] first_addr_o,
    output logic [ADDR_W-1:0] wb_value_o
);
    localparam int SHIFT = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;

    // Byte span covered by the whole transfer
    assign span = {{(ADDR_W-CNT_W){1'b0}}, count_i} << SHIFT;

    // Pick the starting address for each walk mode
    always_comb begin
        case (mode_i)
            WALK_INC_AFTER:  first_addr_o = base_i;
            WALK_INC_BEFORE: first_addr_o = base_i + STEP;
            WALK_DEC_AFTER:  first_addr_o = base_i - span + STEP;
            default:         first_addr_o = base_i - span;
        endcase
    end

    // Written-back base moves by the span in the walk direction
    assign wb_value_o = mode_i[1] ? (base_i - span) : (base_i + span);
endmodule

// File: rtl/xfer_pick_lowest.sv
// Finds the lowest pending register, the mask with it removed, and
// whether it is the final one.
// Assumes: idx_o is meaningful only when pend_i is non-zero.
module xfer_pick_lowest #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     rest_o,
    output logic             last_o
);
    // Priority scan toward the lowest set bit
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign rest_o = pend_i & (pend_i - N'(1));
    assign last_o = (pend_i != '0) && (rest_o == '0);
endmodule

// File: rtl/blk_xfer_seq.sv
// Block transfer sequencer: accepts a start when idle, issues one
// word request per set mask bit over valid/ready, then pulses done
// with the write-back value and side-effect flags.
// Assumes: synchronous active-low reset; the top mask bit is the
// program counter.
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   list_i,
    input  logic [1:0]        mode_i,
    input  logic              wback_i,
    input  logic              load_i,
    input  logic              sbit_i,
    output logic              busy_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [IDX_W-1:0]  req_idx_o,
    output logic              req_load_o,
    output logic              done_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_value_o,
    output logic              pc_load_o,
    output logic              psr_restore_o,
    output logic              user_bank_o
);
    localparam int PC_IDX = NREG - 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    seq_state_e        state_q;
    logic [NREG-1:0]   pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wb_val_q;
    logic              load_q, wb_en_q, pc_q, psr_q, user_q;

    logic [CNT_W-1:0]  list_cnt;
    logic [ADDR_W-1:0] plan_first, plan_wb;
    logic [IDX_W-1:0]  pick_idx;
    logic [NREG-1:0]   pick_rest;
    logic              pick_last;
    logic              pc_in_list;

    xfer_popcount #(.N(NREG), .CNT_W(CNT_W)) u_count (
        .bits_i  (list_i),
        .count_o (list_cnt)
    );

    xfer_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i       (base_i),
        .count_i      (list_cnt),
        .mode_i       (walk_mode_e'(mode_i)),
        .first_addr_o (plan_first),
        .wb_value_o   (plan_wb)
    );

    xfer_pick_lowest #(.N(NREG), .IDX_W(IDX_W)) u_pick (
        .pend_i (pend_q),
        .idx_o  (pick_idx),
        .rest_o (pick_rest),
        .last_o (pick_last)
    );

    assign pc_in_list = list_i[PC_IDX];

    // Sequence control: capture on start, step on handshake, pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            pend_q   <= '0;
            addr_q   <= '0;
            wb_val_q <= '0;
            load_q   <= 1'b0;
            wb_en_q  <= 1'b0;
            pc_q     <= 1'b0;
            psr_q    <= 1'b0;
            user_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        pend_q   <= list_i;
                        addr_q   <= plan_first;
                        wb_val_q <= plan_wb;
                        load_q   <= load_i;
                        wb_en_q  <= wback_i;
                        pc_q     <= load_i && pc_in_list;
                        psr_q    <= load_i && pc_in_list && sbit_i;
                        user_q   <= sbit_i && !(load_i && pc_in_list);
                        state_q  <= (list_i == '0) ? SEQ_FINISH : SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (req_ready_i) begin
                        pend_q <= pick_rest;
                        addr_q <= addr_q + STEP;
                        if (pick_last) state_q <= SEQ_FINISH;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Request port and completion outputs from the state
    assign busy_o        = (state_q != SEQ_IDLE);
    assign req_valid_o   = (state_q == SEQ_RUN);
    assign req_addr_o    = addr_q;
    assign req_idx_o     = pick_idx;
    assign req_load_o    = req_valid_o && load_q;
    assign done_o        = (state_q == SEQ_FINISH);
    assign wb_en_o       = done_o && wb_en_q;
    assign wb_value_o    = done_o ? wb_val_q : '0;
    assign pc_load_o     = done_o && pc_q;
    assign psr_restore_o = done_o && psr_q;
    assign user_bank_o   = done_o && user_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
// Protocol checker for blk_xfer_seq, attached by bind.
// Assumes: req_ready_i may change in any cycle.
module blk_xfer_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [NREG-1:0]   list_i,
    input logic              busy_o,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [IDX_W-1:0]  req_idx_o,
    input logic              done_o,
    input logic              wb_en_o,
    input logic              pc_load_o,
    input logic              psr_restore_o,
    input logic              user_bank_o
);
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !req_valid_o); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> (!req_valid_o || req_addr_o == $past(req_addr_o) + 32'd4)); // R2
    AST_IDX_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ready_i) |=> (!req_valid_o || req_idx_o > $past(req_idx_o))); // R2
    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o); // R4
    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_idx_o))); // R5
    AST_PC_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> done_o); // R6
    AST_RESTORE_NEEDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        psr_restore_o |-> (pc_load_o && !user_bank_o)); // R7
    AST_EMPTY_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && list_i == '0) |=> (done_o && !req_valid_o)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i && start_i) |=> req_valid_o); // R9
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (.*);

// File: tb/blk_xfer_seq_test.sv
// Bench: behavioural queue model of the sequencer, compared every cycle.
module blk_xfer_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] list_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wback_i = 1'b0, load_i = 1'b0, sbit_i = 1'b0;
    logic        req_ready_i = 1'b0;
    logic        busy_o, req_valid_o, req_load_o, done_o, wb_en_o;
    logic        pc_load_o, psr_restore_o, user_bank_o;
    logic [31:0] req_addr_o, wb_value_o;
    logic [3:0]  req_idx_o;

    int checks = 0;
    int failures = 0;
    int ready_pct = 100;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_xfer_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .list_i(list_i), .mode_i(mode_i), .wback_i(wback_i), .load_i(load_i),
        .sbit_i(sbit_i), .busy_o(busy_o), .req_valid_o(req_valid_o),
        .req_ready_i(req_ready_i), .req_addr_o(req_addr_o), .req_idx_o(req_idx_o),
        .req_load_o(req_load_o), .done_o(done_o), .wb_en_o(wb_en_o),
        .wb_value_o(wb_value_o), .pc_load_o(pc_load_o),
        .psr_restore_o(psr_restore_o), .user_bank_o(user_bank_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state
    int          ph = 0;
    logic [31:0] qa[$];
    int          qi[$];
    logic        e_load, e_wb, e_pc, e_psr, e_user;
    logic [31:0] e_wbv;

    task automatic model_accept();
        int n = 0;
        logic [31:0] a;
        for (int i = 0; i < 16; i++) if (list_i[i]) n++;
        case (mode_i)
            2'd0: a = base_i;
            2'd1: a = base_i + 32'd4;
            2'd2: a = base_i - 32'(4 * n) + 32'd4;
            default: a = base_i - 32'(4 * n);
        endcase
        for (int i = 0; i < 16; i++) begin
            if (list_i[i]) begin
                qa.push_back(a);
                qi.push_back(i);
                a = a + 32'd4;
            end
        end
        e_wbv  = (mode_i >= 2'd2) ? base_i - 32'(4 * n) : base_i + 32'(4 * n);
        e_wb   = wback_i;
        e_load = load_i;
        e_pc   = load_i && list_i[15];
        e_psr  = load_i && list_i[15] && sbit_i;
        e_user = sbit_i && !(load_i && list_i[15]);
        ph     = (n == 0) ? 2 : 1;
    endtask

    // Model step at each edge, then compare a quarter period later
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            qa.delete();
            qi.delete();
        end else begin
            case (ph)
                0: if (start_i) model_accept();
                1: if (req_ready_i) begin
                       void'(qa.pop_front());
                       void'(qi.pop_front());
                       if (qa.size() == 0) ph = 2;
                   end
                default: ph = 0;
            endcase
        end
        #(CLK_PERIOD/4);
        if (rst_n) begin
            chk("R9 busy", 32'(busy_o), 32'(ph != 0));
            chk("R1 valid", 32'(req_valid_o), 32'(ph == 1));
            if (ph == 1) begin
                chk("R3 R2 address", req_addr_o, qa[0]);
                chk("R2 index", 32'(req_idx_o), 32'(qi[0]));
                chk("R6 direction", 32'(req_load_o), 32'(e_load));
            end
            chk("R8 R9 done", 32'(done_o), 32'(ph == 2));
            chk("R4 wb enable", 32'(wb_en_o), 32'(ph == 2 && e_wb));
            chk("R4 wb value", wb_value_o, (ph == 2) ? e_wbv : 32'd0);
            chk("R6 pc load", 32'(pc_load_o), 32'(ph == 2 && e_pc));
            chk("R7 restore", 32'(psr_restore_o), 32'(ph == 2 && e_psr));
            chk("R7 user bank", 32'(user_bank_o), 32'(ph == 2 && e_user));
        end
    end

    // Ready generator; R5 is exercised whenever it drops with a request up
    always @(negedge clk) req_ready_i <= ($urandom_range(99) < ready_pct);

    task automatic run_op(logic [31:0] b, logic [15:0] l, logic [1:0] m,
                          logic w, logic ld, logic s, bit poke);
        int guard = 0;
        @(negedge clk);
        base_i = b; list_i = l; mode_i = m; wback_i = w; load_i = ld; sbit_i = s;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R9: start with other operands while busy must be ignored
            base_i = 32'hDEAD_0000; list_i = 16'h0F0F; mode_i = 2'd1;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (ph != 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", 32'(busy_o), 32'd0);
        chk("R10 valid", 32'(req_valid_o), 32'd0);
        chk("R10 done", 32'(done_o), 32'd0);
        rst_n = 1'b1;
        ready_pct = 100;
        run_op(32'h0000_1000, 16'h00F1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        ready_pct = 50;
        run_op(32'h0000_2000, 16'h8003, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        ready_pct = 30;
        run_op(32'h0000_3000, 16'h0A50, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0);
        ready_pct = 70;
        run_op(32'h0000_0040, 16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        run_op(32'h0000_0010, 16'h00FF, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
        // R8: empty mask
        run_op(32'h0000_5000, 16'h0000, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0);
        run_op(32'h0000_6000, 16'h0001, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        ready_pct = 20;
        run_op(32'h0000_7000, 16'h8421, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 30; k++) begin
            ready_pct = $urandom_range(10, 100);
            run_op($urandom, 16'($urandom), 2'($urandom), 1'($urandom),
                   1'($urandom), 1'($urandom), ($urandom_range(3) == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule